// File: doc/BRIEF.md
# RAID6 P/Q Parity Datapath

This block computes RAID parity across a set of equal-length source buffers that are streamed through it. In XOR mode it produces only P, the byte-wise XOR of every source. In dual mode it produces P and Q together in one pass. Q is the GF(2^8) sum of every source byte multiplied by that source's own coefficient. The reduction polynomial can be programmed.

Each operation opens with a start handshake, which carries the mode, the source count, the per-source length in bytes and the Q coefficients. Data is then presented position by position. For every beat position, one beat from each source is sent, each tagged with its source index. Once the last source of a position has been absorbed, the P and Q beats for that position appear on a valid/ready output. A continuation option treats a previously computed P and Q (or the previous XOR result) as extra sources, so that a long stripe can be folded in over several operations. A one-cycle done pulse marks the end of the operation.

Top module: `raid_pq_engine`

## Requirements
- R1: After reset, start_ready is 1 and in_ready, out_valid, done and op_reject are all 0.
- R2: For each beat position, out_p is the XOR of all beats accepted for that position. Byte lane k (bits 8k+7:8k) is independent of the other lanes. The result appears, with out_valid, on the cycle after the last source beat of the position is accepted, and never earlier.
- R3: In dual mode, out_q is the XOR of gf(data, coefficient) over the accepted beats. The coefficient is byte i (bits 8i+7:8i) of start_qcoef, selected by the beat's in_src tag i, so the order of arrival within a position does not matter.
- R4: In XOR mode (start_dual = 0), out_q is 0 whatever start_qcoef holds.
- R5: A dual-mode start with a single source (start_nsrc_m1 = 0) is rejected. op_reject pulses high for one cycle, the block stays idle, and no beat is accepted. A Q-only result for one source is obtained by sending it twice with the second coefficient set to 0.
- R6: A start whose start_len is 0, is not a multiple of LANES bytes, or exceeds 1048576 bytes is rejected as in R5.
- R7: Dual continuation (start_cont = 1) appends three sources with tags n, n+1 and n+2 (n = data source count), carrying old P, old Q and old Q. Their Q coefficients are 0, 0 and 1, and every source has a P coefficient of 1.
- R8: XOR continuation appends one source with tag n, carrying the old result, and folds it into P.
- R9: cfg_we writes the low byte of the reduction polynomial (x^8 implicit). The reset value is 0x1D, which stands for 0x11D.
- R10: done is high for exactly one cycle, on the same cycle as out_valid of the final position. start_ready is 1 on that cycle.
- R11: While out_valid is high and out_ready is low, out_p and out_q hold and in_ready is 0.
- R12: The accumulators are cleared on start and after every position, so one operation's result never depends on earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the polynomial |
| cfg_poly | input | 8 | Polynomial low byte |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Block idle, start can be taken |
| start_dual | input | 1 | 1 = P and Q, 0 = P only |
| start_cont | input | 1 | Continuation: append old results as sources |
| start_nsrc_m1 | input | 4 | Data source count minus one |
| start_len | input | 21 | Bytes per source |
| start_qcoef | input | 128 | Q coefficient per data source, byte i for tag i |
| op_reject | output | 1 | One-cycle pulse when a start is refused |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Source beat can be taken |
| in_src | input | 5 | Source tag of the beat |
| in_data | input | 32 | Source beat, LANES bytes |
| out_valid | output | 1 | Parity beat valid |
| out_ready | input | 1 | Parity beat taken |
| out_p | output | 32 | P beat |
| out_q | output | 32 | Q beat |
| done | output | 1 | End-of-operation pulse |

## Verification
A wrong source counter shows up within one position: out_valid arrives one beat early or late, and P misses a source or folds one in twice. A wrong coefficient slot or continuation offset corrupts only Q, and it does so on the first position that uses that tag. A faulty multiplier or polynomial register is caught by a sweep of all 256 coefficients against all 256 data values. A beat-counter error moves the done pulse away from the final position. An error in the output hold under back-pressure shows as a changed out_p, or a raised in_ready, while out_ready is low.

// File: rtl/raid_pq_pkg.sv
// Shared constants and the GF(2^8) multiply used by the parity datapath.
// Assumes polynomials are given as their low byte with x^8 implicit.
package raid_pq_pkg;

    // Extra sources appended at most by a continuation operation
    localparam int EXTRA_MAX = 3;

    // Shift-and-reduce GF(2^8) product over 8 iterations
    function automatic logic [7:0] gf_mul(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [7:0] poly);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? poly : 8'h00);
        end
        return acc;
    endfunction

endpackage

// File: rtl/raid_pq_gfmul.sv
// One byte-wide combinational GF(2^8) multiplier.
// Assumes poly holds the reduction polynomial without its x^8 term.
module raid_pq_gfmul (
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic [7:0] poly,
    output logic [7:0] prod
);
    import raid_pq_pkg::*;

    // Product of the data byte and the coefficient
    always_comb prod = gf_mul(a, b, poly);

endmodule

// File: rtl/raid_pq_ctrl.sv
// Operation control: checks a start request, tracks the source and beat
// position, and raises the group-end and done events.
// Assumes beats arrive position-major and source-minor.
module raid_pq_ctrl #(
    parameter int MAX_SRC   = 16,
    parameter int LANES     = 4,
    parameter int MAX_BYTES = 1048576
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_valid,
    input  logic                               start_dual,
    input  logic                               start_cont,
    input  logic [$clog2(MAX_SRC)-1:0]         start_nsrc_m1,
    input  logic [$clog2(MAX_BYTES):0]         start_len,
    output logic                               start_ready,
    output logic                               start_fire,
    output logic                               op_reject,
    input  logic                               in_valid,
    input  logic                               out_pending,
    output logic                               in_ready,
    output logic                               in_fire,
    output logic                               group_end,
    output logic                               done
);
    localparam int CNT_W   = $clog2(MAX_SRC);
    localparam int IDX_W   = $clog2(MAX_SRC + raid_pq_pkg::EXTRA_MAX);
    localparam int LEN_W   = $clog2(MAX_BYTES) + 1;
    localparam int LANE_SH = $clog2(LANES);
    localparam int BEAT_W  = LEN_W - LANE_SH;

    logic              busy;
    logic [IDX_W-1:0]  last_src, src_ctr, extra;
    logic [BEAT_W-1:0] last_beat, beat_ctr;
    logic              len_ok, src_ok;

    // Number of sources appended by continuation
    always_comb begin
        if (!start_cont)     extra = '0;
        else if (start_dual) extra = IDX_W'(3);
        else                 extra = IDX_W'(1);
    end

    // Start request legality: length and minimum source count
    always_comb begin
        len_ok = (start_len != '0) &&
                 ((start_len & LEN_W'(LANES - 1)) == '0) &&
                 (start_len <= LEN_W'(MAX_BYTES));
        src_ok = !(start_dual && (start_nsrc_m1 == '0));
    end

    // Handshake qualifiers
    always_comb begin
        start_ready = !busy;
        start_fire  = start_valid && !busy && len_ok && src_ok;
        in_ready    = busy && !out_pending;
        in_fire     = in_valid && in_ready;
        group_end   = in_fire && (src_ctr == last_src);
    end

    // Operation state and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            op_reject <= 1'b0;
            last_src  <= '0;
            last_beat <= '0;
            src_ctr   <= '0;
            beat_ctr  <= '0;
        end else begin
            done      <= 1'b0;
            op_reject <= start_valid && !busy && !(len_ok && src_ok);
            if (start_fire) begin
                busy      <= 1'b1;
                last_src  <= IDX_W'(start_nsrc_m1) + extra;
                last_beat <= start_len[LEN_W-1:LANE_SH] - BEAT_W'(1);
                src_ctr   <= '0;
                beat_ctr  <= '0;
            end else if (in_fire) begin
                if (src_ctr == last_src) begin
                    src_ctr <= '0;
                    if (beat_ctr == last_beat) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        beat_ctr <= beat_ctr + BEAT_W'(1);
                    end
                end else begin
                    src_ctr <= src_ctr + IDX_W'(1);
                end
            end
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_ready);
    assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |-> (start_ready && !in_ready));
    assert_ctr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (src_ctr <= last_src && beat_ctr <= last_beat));

endmodule

// File: rtl/raid_pq_coefs.sv
// Q coefficient table loaded on start. Data sources take their programmed
// coefficient in dual mode; the continuation slots get 0, 0, 1; everything
// is 0 in XOR mode. Assumes load only while the block is idle.
module raid_pq_coefs #(
    parameter int MAX_SRC = 16
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              load,
    input  logic                                              dual,
    input  logic                                              cont,
    input  logic [$clog2(MAX_SRC)-1:0]                        nsrc_m1,
    input  logic [MAX_SRC*8-1:0]                              qcoef_in,
    input  logic [$clog2(MAX_SRC+raid_pq_pkg::EXTRA_MAX)-1:0] sel,
    output logic [7:0]                                        coef
);
    localparam int IDX_W = $clog2(MAX_SRC + raid_pq_pkg::EXTRA_MAX);
    localparam int SLOTS = 1 << IDX_W;

    logic [IDX_W-1:0] n_src;
    logic [7:0]       slot [SLOTS];

    // Data source count
    always_comb n_src = IDX_W'(nsrc_m1) + IDX_W'(1);

    for (genvar i = 0; i < SLOTS; i++) begin : gen_slot
        if (i < MAX_SRC) begin : gen_data
            // Slot that may hold a programmed data coefficient
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[i] <= 8'h00;
                else if (load) begin
                    if (dual && IDX_W'(i) < n_src)
                        slot[i] <= qcoef_in[i*8 +: 8];
                    else if (dual && cont && IDX_W'(i) == n_src + IDX_W'(2))
                        slot[i] <= 8'h01;
                    else
                        slot[i] <= 8'h00;
                end
            end
        end else begin : gen_ext
            // Slot reachable only by continuation sources
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[i] <= 8'h00;
                else if (load)
                    slot[i] <= (dual && cont && IDX_W'(i) == n_src + IDX_W'(2))
                               ? 8'h01 : 8'h00;
            end
        end
    end

    // Coefficient of the current beat's tag
    always_comb coef = slot[sel];

endmodule

// File: rtl/raid_pq_lanes.sv
// Byte-lane datapath: a multiplier per lane, the P and Q accumulators and
// the output register. Assumes clear and fire never coincide.
module raid_pq_lanes #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               fire,
    input  logic               group_end,
    input  logic [LANES*8-1:0] data,
    input  logic [7:0]         coef,
    input  logic [7:0]         poly,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [LANES*8-1:0] out_p,
    output logic [LANES*8-1:0] out_q
);
    localparam int DW = LANES * 8;

    logic [DW-1:0] prod, acc_p, acc_q;

    for (genvar l = 0; l < LANES; l++) begin : gen_lane
        raid_pq_gfmul u_mul (
            .a    (data[l*8 +: 8]),
            .b    (coef),
            .poly (poly),
            .prod (prod[l*8 +: 8])
        );
    end

    // Accumulate a beat; at the last source, publish the result and restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_p     <= '0;
            acc_q     <= '0;
            out_p     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            if (clear) begin
                acc_p <= '0;
                acc_q <= '0;
            end else if (fire) begin
                if (group_end) begin
                    acc_p <= '0;
                    acc_q <= '0;
                    out_p <= acc_p ^ data;
                    out_q <= acc_q ^ prod;
                end else begin
                    acc_p <= acc_p ^ data;
                    acc_q <= acc_q ^ prod;
                end
            end
            if (fire && group_end)
                out_valid <= 1'b1;
            else if (out_ready)
                out_valid <= 1'b0;
        end
    end

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));
    assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        group_end |-> !out_valid);

endmodule

// File: rtl/raid_pq_engine.sv
// RAID parity engine top: P-only or P+Q over streamed sources, with
// continuation and a programmable reduction polynomial.
// Assumes sources arrive one beat per source per position, position by position.
module raid_pq_engine #(
    parameter int         MAX_SRC    = 16,
    parameter int         LANES      = 4,
    parameter int         MAX_BYTES  = 1048576,
    parameter logic [7:0] POLY_RESET = 8'h1D
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              cfg_we,
    input  logic [7:0]                                        cfg_poly,
    input  logic                                              start_valid,
    output logic                                              start_ready,
    input  logic                                              start_dual,
    input  logic                                              start_cont,
    input  logic [$clog2(MAX_SRC)-1:0]                        start_nsrc_m1,
    input  logic [$clog2(MAX_BYTES):0]                        start_len,
    input  logic [MAX_SRC*8-1:0]                              start_qcoef,
    output logic                                              op_reject,
    input  logic                                              in_valid,
    output logic                                              in_ready,
    input  logic [$clog2(MAX_SRC+raid_pq_pkg::EXTRA_MAX)-1:0] in_src,
    input  logic [LANES*8-1:0]                                in_data,
    output logic                                              out_valid,
    input  logic                                              out_ready,
    output logic [LANES*8-1:0]                                out_p,
    output logic [LANES*8-1:0]                                out_q,
    output logic                                              done
);
    logic [7:0] poly_r;
    logic [7:0] coef;
    logic       start_fire, in_fire, group_end;

    // Reduction polynomial register
    always_ff @(posedge clk) begin
        if (!rst_n)      poly_r <= POLY_RESET;
        else if (cfg_we) poly_r <= cfg_poly;
    end

    raid_pq_ctrl #(.MAX_SRC(MAX_SRC), .LANES(LANES), .MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .start_dual    (start_dual),
        .start_cont    (start_cont),
        .start_nsrc_m1 (start_nsrc_m1),
        .start_len     (start_len),
        .start_ready   (start_ready),
        .start_fire    (start_fire),
        .op_reject     (op_reject),
        .in_valid      (in_valid),
        .out_pending   (out_valid),
        .in_ready      (in_ready),
        .in_fire       (in_fire),
        .group_end     (group_end),
        .done          (done)
    );

    raid_pq_coefs #(.MAX_SRC(MAX_SRC)) u_coefs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_fire),
        .dual     (start_dual),
        .cont     (start_cont),
        .nsrc_m1  (start_nsrc_m1),
        .qcoef_in (start_qcoef),
        .sel      (in_src),
        .coef     (coef)
    );

    raid_pq_lanes #(.LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_fire),
        .fire      (in_fire),
        .group_end (group_end),
        .data      (in_data),
        .coef      (coef),
        .poly      (poly_r),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_p     (out_p),
        .out_q     (out_q)
    );

    assert_in_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    assert_poly_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(poly_r));

endmodule

// File: tb/tb_raid_pq_engine.sv
// Self-checking bench: coefficient x data sweep, polynomial change, modes,
// continuation, rejects, back-pressure.
module tb_raid_pq_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_poly = 8'h00;
    logic         start_valid = 1'b0;
    logic         start_ready;
    logic         start_dual = 1'b0;
    logic         start_cont = 1'b0;
    logic [3:0]   start_nsrc_m1 = 4'd0;
    logic [20:0]  start_len = 21'd0;
    logic [127:0] start_qcoef = '0;
    logic         op_reject;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [4:0]   in_src = 5'd0;
    logic [31:0]  in_data = 32'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_p, out_q;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    raid_pq_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly(cfg_poly),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_dual(start_dual), .start_cont(start_cont),
        .start_nsrc_m1(start_nsrc_m1), .start_len(start_len),
        .start_qcoef(start_qcoef), .op_reject(op_reject),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_p(out_p), .out_q(out_q), .done(done)
    );

    // Carry-less product then polynomial reduction from the top bit down
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                           input logic [7:0] pl);
        logic [14:0] pr;
        pr = '0;
        for (int i = 0; i < 8; i++)
            if (b[i]) pr = pr ^ (15'(a) << i);
        for (int k = 14; k >= 8; k--)
            if (pr[k]) pr = pr ^ (15'({1'b1, pl}) << (k - 8));
        return pr[7:0];
    endfunction

    function automatic logic [31:0] mul4(input logic [31:0] d, input logic [7:0] c,
                                         input logic [7:0] pl);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = ref_mul(d[l*8 +: 8], c, pl);
        return r;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic start_op(input logic dual, input logic cont, input logic [3:0] nm1,
                            input logic [20:0] len, input logic [127:0] qc);
        start_dual = dual; start_cont = cont; start_nsrc_m1 = nm1;
        start_len = len; start_qcoef = qc; start_valid = 1'b1;
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic send(input logic [4:0] tag, input logic [31:0] d);
        in_valid = 1'b1; in_src = tag; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic reject_case(input string what, input logic dual, input logic [3:0] nm1,
                               input logic [20:0] len);
        start_op(dual, 1'b0, nm1, len, '0);
        chk({what, " op_reject pulse"}, {31'd0, op_reject}, 32'd1);
        chk({what, " stays idle"}, {31'd0, start_ready}, 32'd1);
        chk({what, " no beat taken"}, {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        chk({what, " op_reject one cycle"}, {31'd0, op_reject}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d0, e, acc_p, acc_q, hold_p, hold_q;
        logic [127:0] qc;
        logic [7:0]   cf [4];
        int           order [4];

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 start_ready", {31'd0, start_ready}, 32'd1);
        chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {29'd0, start_ready, out_valid, done}, 32'd4);
        chk("R1 op_reject", {31'd0, op_reject}, 32'd0);

        // R2 R3 R9: every coefficient against every data byte, reset polynomial
        for (int c = 0; c < 256; c++) begin
            qc = '0; qc[7:0] = c[7:0]; qc[15:8] = 8'h01;
            start_op(1'b1, 1'b0, 4'd1, 21'd256, qc);
            for (int b = 0; b < 64; b++) begin
                d0 = {8'(4*b+3), 8'(4*b+2), 8'(4*b+1), 8'(4*b)};
                e  = {d0[15:0], d0[31:16]} ^ 32'h5a5a5a5a ^ {4{c[7:0]}};
                send(5'd0, d0);
                if (b == 0) chk("R2 no output before last source", {31'd0, out_valid}, 32'd0);
                send(5'd1, e);
                chk("R2 out_valid after last source", {31'd0, out_valid}, 32'd1);
                chk("R2 P sweep", out_p, d0 ^ e);
                chk("R3 R9 Q sweep default poly", out_q, mul4(d0, c[7:0], 8'h1d) ^ e);
                chk("R10 done only on final position", {31'd0, done}, (b == 63) ? 32'd1 : 32'd0);
            end
            chk("R10 start_ready with done", {31'd0, start_ready}, 32'd1);
        end
        @(negedge clk);
        chk("R10 done falls", {31'd0, done}, 32'd0);

        // R9: programmed polynomial 0x12B
        cfg_we = 1'b1; cfg_poly = 8'h2b;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int c = 0; c < 256; c += 5) begin
            qc = '0; qc[7:0] = c[7:0]; qc[15:8] = 8'h01;
            start_op(1'b1, 1'b0, 4'd1, 21'd16, qc);
            for (int b = 0; b < 4; b++) begin
                d0 = {8'(b*64+c), 8'(b*64+c+1), 8'(255-c), 8'(c*3+b)};
                e  = 32'h0f1e2d3c ^ {4{8'(b)}};
                send(5'd0, d0);
                send(5'd1, e);
                chk("R9 Q with polynomial 0x12B", out_q, mul4(d0, c[7:0], 8'h2b) ^ e);
            end
        end
        cfg_we = 1'b1; cfg_poly = 8'h1d;
        @(negedge clk);
        cfg_we = 1'b0;

        // R2 R4: XOR mode, all 16 sources, coefficients given but ignored
        start_op(1'b0, 1'b0, 4'd15, 21'd8, {16{8'hff}});
        for (int b = 0; b < 2; b++) begin
            acc_p = '0;
            for (int s = 0; s < 16; s++) begin
                d0 = {8'(s*17+b), 8'(s*3+7), 8'(~s), 8'((s << 4) | b)};
                send(5'(s), d0);
                acc_p = acc_p ^ d0;
            end
            chk("R2 P over 16 sources", out_p, acc_p);
            chk("R4 Q zero in XOR mode", out_q, 32'd0);
        end

        // R3: coefficient follows the tag, not the arrival order
        cf = '{8'h02, 8'h03, 8'h8e, 8'hff};
        order = '{2, 0, 3, 1};
        qc = '0;
        for (int i = 0; i < 4; i++) qc[i*8 +: 8] = cf[i];
        start_op(1'b1, 1'b0, 4'd3, 21'd4, qc);
        acc_p = '0; acc_q = '0;
        for (int i = 0; i < 4; i++) begin
            d0 = {4{8'(order[i]*37+5)}} ^ 32'h00ff00ff;
            send(5'(order[i]), d0);
            acc_p = acc_p ^ d0;
            acc_q = acc_q ^ mul4(d0, cf[order[i]], 8'h1d);
        end
        chk("R3 P permuted tags", out_p, acc_p);
        chk("R3 Q permuted tags", out_q, acc_q);

        // R5: single-source Q-only by sending the source twice
        qc = '0; qc[7:0] = 8'h35; qc[15:8] = 8'h00;
        start_op(1'b1, 1'b0, 4'd1, 21'd4, qc);
        d0 = 32'hc3a51e77;
        send(5'd0, d0);
        send(5'd1, d0);
        chk("R5 Q-only P cancels", out_p, 32'd0);
        chk("R5 Q-only Q", out_q, mul4(d0, 8'h35, 8'h1d));

        // R7: dual continuation
        qc = '0; qc[7:0] = 8'h1d; qc[15:8] = 8'h47; qc[23:16] = 8'ha0;
        start_op(1'b1, 1'b1, 4'd2, 21'd4, qc);
        acc_p = 32'hdeadbeef; acc_q = 32'h0badf00d;
        for (int s = 0; s < 3; s++) begin
            d0 = 32'h13579bdf + 32'(s) * 32'h02040608;
            send(5'(s), d0);
            acc_p = acc_p ^ d0;
            acc_q = acc_q ^ mul4(d0, qc[s*8 +: 8], 8'h1d);
        end
        send(5'd3, 32'hdeadbeef);
        send(5'd4, 32'h0badf00d);
        chk("R7 no output before third appended source", {31'd0, out_valid}, 32'd0);
        send(5'd5, 32'h0badf00d);
        chk("R7 P with old P folded", out_p, acc_p);
        chk("R7 Q with old Q folded", out_q, acc_q);

        // R8: XOR continuation
        start_op(1'b0, 1'b1, 4'd1, 21'd4, '0);
        send(5'd0, 32'h11112222);
        send(5'd1, 32'h0f0f0f0f);
        chk("R8 no output before appended source", {31'd0, out_valid}, 32'd0);
        send(5'd2, 32'h80808001);
        chk("R8 P with old result", out_p, 32'h11112222 ^ 32'h0f0f0f0f ^ 32'h80808001);

        // R5 R6: rejected starts
        reject_case("R5 dual one source", 1'b1, 4'd0, 21'd4);
        reject_case("R6 zero length", 1'b0, 4'd0, 21'd0);
        reject_case("R6 unaligned length", 1'b0, 4'd0, 21'd6);
        reject_case("R6 over 1 MiB", 1'b0, 4'd3, 21'd1048580);

        // R12: fresh operation after earlier data gives its own result only
        start_op(1'b0, 1'b0, 4'd0, 21'd4, '0);
        chk("R6 legal start accepted", {31'd0, op_reject}, 32'd0);
        send(5'd0, 32'h5ee1ab1e);
        chk("R12 P after clear", out_p, 32'h5ee1ab1e);
        chk("R12 Q after clear", out_q, 32'd0);

        // R11: back-pressure on the output
        qc = '0; qc[7:0] = 8'h03; qc[15:8] = 8'h01;
        start_op(1'b1, 1'b0, 4'd1, 21'd8, qc);
        send(5'd0, 32'h01020304);
        out_ready = 1'b0;
        send(5'd1, 32'hf0e0d0c0);
        hold_p = out_p; hold_q = out_q;
        chk("R11 P before stall", hold_p, 32'h01020304 ^ 32'hf0e0d0c0);
        chk("R11 Q before stall", hold_q, mul4(32'h01020304, 8'h03, 8'h1d) ^ 32'hf0e0d0c0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 out_valid held", {31'd0, out_valid}, 32'd1);
            chk("R11 out_p held", out_p, hold_p);
            chk("R11 out_q held", out_q, hold_q);
            chk("R11 in_ready low", {31'd0, in_ready}, 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11 released", {31'd0, out_valid}, 32'd0);
        send(5'd1, 32'h0000ffff);
        send(5'd0, 32'h12345678);
        chk("R11 next position P", out_p, 32'h0000ffff ^ 32'h12345678);
        chk("R10 done at end", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule